// File: doc/BRIEF.md
# Configurable SPI Master/Slave Port

A byte-wide synchronous serial port that works either as the clock-generating master or as a clocked slave, set up through one 8-bit control word on a small register bus. Software places a byte in the data register; in master mode that write starts an 8-bit exchange, and in slave mode it preloads the byte the external master will clock out. Each byte that arrives lands in a receive buffer and sets a buffer-full status bit. Reading the buffer clears that bit.

Two sticky flags in the control word report misuse. One marks a data write made while a byte is still shifting. The other marks a slave byte that arrived while the buffer still held an unread byte. Software clears each flag by writing 0 to it. The master clock comes from one of three fixed dividers of the system clock or from an external timer tick. In slave mode the select input can gate the transfer, or it can be ignored. Data moves most significant bit first. Each bit is sampled on the leading clock edge (the first edge away from the idle level) and the next bit is driven on the trailing edge.

Top module: `spi_port_top`

## Requirements
- R1: After reset the control word reads 0x00, the status word reads 0x00, and `sck_oe` and `sdo_oe` are both 0.
- R2: With the enable bit (control bit 5) at 0, both output enables stay 0. A data write then starts no transfer, and the status word stays 0x00.
- R3: Master mode codes (control bits 3..0) 0, 1 and 2 give an SCK half-period of 2, 8 and 32 system clocks. The buffer-full bit rises exactly 16 half-periods after the clock edge that takes the data write. Code 3 toggles SCK once per `timer_tick` pulse.
- R4: A transfer moves 8 bits, most significant bit first. SDI is sampled on each leading SCK edge and SDO changes only on trailing edges. The received byte is loaded into the buffer when the byte completes.
- R5: The clock polarity bit (control bit 4) sets the idle SCK level: 1 gives high and 0 gives low.
- R6: A data write while a byte is shifting sets the write-collision flag (control bit 7) and does not alter the byte in flight. Writing 1 to the flag leaves it set, and writing 0 clears it.
- R7: In slave mode, a byte that completes while the buffer is full sets the overflow flag (control bit 6). That byte is discarded and the buffer keeps the older byte. Master mode never sets the overflow flag.
- R8: Reading the data register (address 2) clears the buffer-full status bit.
- R9: In mode code 4 the active-low select input gates the slave. While it is high, `sdo_oe` is 0, edges are ignored and the bit count returns to zero. Mode code 5 ignores the select input.
- R10: Mode codes 6 to 15 leave the port idle even when enabled: no output enable, no transfer, and the busy bit stays 0.
- R11: Register addresses are 0 for control, 1 for status and 2 for data. In the status word, bit 0 is buffer full and bit 1 is shift busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on data register) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| timer_tick | input | 1 | Tick pulse for the timer-clocked master mode |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock output enable |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data output enable |
| ss_n_i | input | 1 | Active-low slave select |

## Verification
On every cycle, the assertions check the following: the output enables are dropped when the port is off, held low in reserved modes, and dropped while the select is high. SCK rests at the polarity level when the master is idle. The master clock phase moves only on a divider step or a timer tick. The collision flag follows a busy write. The buffer holds its value across an overflow. Overflow rises only in slave mode. The bench scenarios are needed for the end-to-end properties: the exact cycle count of each divider, the bit order seen on SDO and recovered from SDI, the byte that survives a collision or an overflow, and the restart of the slave bit count after a select pulse in the middle of a byte.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  localparam int BYTE_W = 8;

  localparam logic [1:0] ADDR_CTL  = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  localparam logic [3:0] MODE_DIV_A  = 4'd0;
  localparam logic [3:0] MODE_DIV_B  = 4'd1;
  localparam logic [3:0] MODE_DIV_C  = 4'd2;
  localparam logic [3:0] MODE_TIMER  = 4'd3;
  localparam logic [3:0] MODE_SL_SEL = 4'd4;
  localparam logic [3:0] MODE_SL_ANY = 4'd5;

  typedef struct packed {
    logic       wcol;
    logic       ovf;
    logic       en;
    logic       cpol;
    logic [3:0] mode;
  } ctl_t;

  // Master modes occupy codes 0..3
  function automatic logic mode_is_master(input logic [3:0] m);
    return m <= MODE_TIMER;
  endfunction

  function automatic logic mode_is_slave(input logic [3:0] m);
    return (m == MODE_SL_SEL) || (m == MODE_SL_ANY);
  endfunction

  // Half-period in system clocks: base, base*4, base*16 for the divider codes
  function automatic int unsigned half_clocks(input logic [1:0] sel, input int unsigned base);
    return base << (2 * int'(sel));
  endfunction

endpackage

// File: rtl/spi_port_clkgen.sv
module spi_port_clkgen #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            use_tmr,
  input  logic            timer_tick,
  input  logic [DIVW-1:0] half,
  output logic            ph,
  output logic            lead,
  output logic            trail
);

  logic [DIVW-1:0] cnt;
  logic            step;

  assign step  = use_tmr ? timer_tick : (cnt == half - DIVW'(1));
  assign lead  = run & step & ~ph;
  assign trail = run & step & ph;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      ph  <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      ph  <= 1'b0;
    end else if (step) begin
      cnt <= '0;
      ph  <= ~ph;
    end else begin
      cnt <= cnt + DIVW'(1);
    end
  end

  // R3: the clock phase only moves on a divider step
  assert_phase_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !step) |=> $stable(ph));

  // R3: in timer mode the phase waits for a tick
  assert_timer_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && use_tmr && !timer_tick) |=> $stable(ph));

endmodule

// File: rtl/spi_port_slave_front.sv
module spi_port_slave_front (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic use_sel,
  input  logic cpol,
  input  logic sck_i,
  input  logic sdi_i,
  input  logic ss_n_i,
  output logic lead,
  output logic trail,
  output logic sdi_s,
  output logic sel_hold
);

  logic [1:0] sck_sync, sdi_sync, ss_sync;
  logic       lvl, lvl_q;
  logic       gate;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_sync <= 2'b00;
      sdi_sync <= 2'b00;
      ss_sync  <= 2'b11;
      lvl_q    <= 1'b0;
    end else begin
      sck_sync <= {sck_sync[0], sck_i};
      sdi_sync <= {sdi_sync[0], sdi_i};
      ss_sync  <= {ss_sync[0], ss_n_i};
      lvl_q    <= lvl;
    end
  end

  // Active level of the serial clock relative to its idle level
  assign lvl      = sck_sync[1] ^ cpol;
  assign sdi_s    = sdi_sync[1];
  assign sel_hold = use_sel & ss_sync[1];
  assign gate     = active & ~sel_hold;
  assign lead     = gate & lvl & ~lvl_q;
  assign trail    = gate & ~lvl & lvl_q;

endmodule

// File: rtl/spi_port_shifter.sv
module spi_port_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         lead,
  input  logic         trail,
  input  logic         sdi,
  output logic         sdo,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] rx_byte
);

  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  sr;
  logic [CW-1:0] cnt;
  logic          pend;
  logic          rbit;
  logic          last;

  assign last    = (cnt == CW'(W - 1));
  assign done    = ~clr & trail & pend & last;
  assign rx_byte = {sr[W-2:0], rbit};
  assign sdo     = sr[W-1];
  assign busy    = (cnt != '0) | pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr   <= '0;
      cnt  <= '0;
      pend <= 1'b0;
      rbit <= 1'b0;
    end else if (clr) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else if (load) begin
      sr <= load_data;
    end else begin
      if (lead) begin
        rbit <= sdi;
        pend <= 1'b1;
      end
      if (trail && pend) begin
        sr   <= {sr[W-2:0], rbit};
        pend <= 1'b0;
        cnt  <= last ? '0 : cnt + CW'(1);
      end
    end
  end

  // R4: a finished byte leaves the counter at zero
  assert_byte_rearm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (cnt == '0) && !pend);

  // R4: SDO only changes on a trailing edge or a preload
  assert_sdo_trailing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!trail && !load) |=> $stable(sdo));

endmodule

// File: rtl/spi_port_top.sv
module spi_port_top
  import spi_port_pkg::*;
#(
  parameter int DIVW      = 8,
  parameter int BASE_HALF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              timer_tick,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe,
  input  logic              ss_n_i
);

  ctl_t              ctl;
  logic              full;
  logic [BYTE_W-1:0] rx_buf;
  logic              m_active;

  // Decoded mode and bus events
  logic mst, slv, use_sel;
  logic wr_ctl, wr_dat, rd_dat;
  logic start, sload, collide;
  logic busy, sh_busy;
  logic ovf_evt, rx_load;

  // Engine wiring
  logic              m_ph, m_lead, m_trail;
  logic              s_lead, s_trail, s_sdi, sel_hold;
  logic              e_lead, e_trail, e_sdi, e_clr;
  logic              sh_sdo, done;
  logic [BYTE_W-1:0] rx_byte;
  logic [DIVW-1:0]   half;

  assign mst     = ctl.en & mode_is_master(ctl.mode);
  assign slv     = ctl.en & mode_is_slave(ctl.mode);
  assign use_sel = (ctl.mode == MODE_SL_SEL);
  assign half    = DIVW'(half_clocks(ctl.mode[1:0], BASE_HALF));

  assign wr_ctl = reg_wr & (reg_addr == ADDR_CTL);
  assign wr_dat = reg_wr & (reg_addr == ADDR_DATA);
  assign rd_dat = reg_rd & (reg_addr == ADDR_DATA);

  assign busy    = mst ? m_active : (slv ? sh_busy : 1'b0);
  assign start   = wr_dat & mst & ~m_active;
  assign sload   = wr_dat & slv & ~sh_busy;
  assign collide = wr_dat & (mst | slv) & busy;
  assign ovf_evt = done & slv & full;
  assign rx_load = done & ~ovf_evt;

  assign e_lead  = mst ? m_lead  : s_lead;
  assign e_trail = mst ? m_trail : s_trail;
  assign e_sdi   = mst ? sdi_i   : s_sdi;
  assign e_clr   = ~(mst | slv) | (slv & sel_hold);

  spi_port_clkgen #(.DIVW(DIVW)) u_clkgen (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (m_active),
    .use_tmr    (ctl.mode == MODE_TIMER),
    .timer_tick (timer_tick),
    .half       (half),
    .ph         (m_ph),
    .lead       (m_lead),
    .trail      (m_trail)
  );

  spi_port_slave_front u_front (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (slv),
    .use_sel  (use_sel),
    .cpol     (ctl.cpol),
    .sck_i    (sck_i),
    .sdi_i    (sdi_i),
    .ss_n_i   (ss_n_i),
    .lead     (s_lead),
    .trail    (s_trail),
    .sdi_s    (s_sdi),
    .sel_hold (sel_hold)
  );

  spi_port_shifter #(.W(BYTE_W)) u_shifter (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (e_clr),
    .load      (start | sload),
    .load_data (reg_wdata),
    .lead      (e_lead),
    .trail     (e_trail),
    .sdi       (e_sdi),
    .sdo       (sh_sdo),
    .busy      (sh_busy),
    .done      (done),
    .rx_byte   (rx_byte)
  );

  // Control word: flags may only be cleared by software
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl <= '0;
    end else begin
      if (wr_ctl) begin
        ctl.wcol <= ctl.wcol & reg_wdata[7];
        ctl.ovf  <= ctl.ovf & reg_wdata[6];
        ctl.en   <= reg_wdata[5];
        ctl.cpol <= reg_wdata[4];
        ctl.mode <= reg_wdata[3:0];
      end
      if (collide) ctl.wcol <= 1'b1;
      if (ovf_evt) ctl.ovf  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_active <= 1'b0;
    end else if (!mst) begin
      m_active <= 1'b0;
    end else if (start) begin
      m_active <= 1'b1;
    end else if (done) begin
      m_active <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full   <= 1'b0;
      rx_buf <= '0;
    end else if (rx_load) begin
      full   <= 1'b1;
      rx_buf <= rx_byte;
    end else if (rd_dat) begin
      full <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      ADDR_CTL:  reg_rdata = ctl;
      ADDR_STAT: reg_rdata = {{(BYTE_W-2){1'b0}}, busy, full};
      ADDR_DATA: reg_rdata = rx_buf;
      default:   reg_rdata = '0;
    endcase
  end

  assign sck_oe = mst;
  assign sck_o  = ctl.cpol ^ m_ph;
  assign sdo_oe = mst | (slv & ~sel_hold);
  assign sdo_o  = sh_sdo;

  // R2: a disabled port drives nothing
  assert_pins_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.en |-> (!sck_oe && !sdo_oe));

  // R5: an idle master rests SCK at the polarity level
  assert_sck_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mst && !m_active) |-> (sck_o == ctl.cpol));

  // R6: a busy data write raises the collision flag
  assert_collision_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> ctl.wcol);

  // R7: overflow is raised only from slave mode
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl.ovf) |-> $past(slv));

  // R7: the older byte survives an overflow
  assert_buf_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (rx_buf == $past(rx_buf)) && full);

  // R9: a deselected slave releases SDO
  assert_sel_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (slv && sel_hold) |-> !sdo_oe);

  // R10: reserved codes stay idle
  assert_reserved_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.en && !mst && !slv) |-> (!sck_oe && !sdo_oe && !busy));

endmodule

// File: tb/spi_port_top_tb.sv
module spi_port_top_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       timer_tick = 1'b0;
  logic       bsck = 1'b0, bsdi = 1'b0, bss_n = 1'b1;
  logic       sck_o, sck_oe, sdo_o, sdo_oe;

  int vectors = 0, misses = 0;
  bit finished = 1'b0;

  // Bench-side master observer state
  logic       cpol_b = 1'b0;
  logic       prev_lvl = 1'b0;
  logic [7:0] cap = 8'h00, pat = 8'h00;
  int         lead_cnt = 0;
  bit         tmr_en = 1'b0;
  int         tmr_div = 0;

  always #10 clk = ~clk;

  spi_port_top u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .timer_tick(timer_tick), .sck_i(bsck), .sck_o(sck_o), .sck_oe(sck_oe),
    .sdi_i(bsdi), .sdo_o(sdo_o), .sdo_oe(sdo_oe), .ss_n_i(bss_n)
  );

  // Observe the master clock: capture SDO on leading edges, feed SDI on trailing
  always @(negedge clk) begin
    logic lvl;
    lvl = sck_oe & (sck_o ^ cpol_b);
    if (lvl && !prev_lvl) begin
      cap = {cap[6:0], sdo_o};
      lead_cnt++;
    end
    if (!lvl && prev_lvl) begin
      pat  = {pat[6:0], 1'b0};
      bsdi = pat[7];
    end
    prev_lvl = lvl;
  end

  always @(negedge clk) begin
    if (tmr_en) begin
      tmr_div    = (tmr_div == 2) ? 0 : tmr_div + 1;
      timer_tick = (tmr_div == 2);
    end else begin
      timer_tick = 1'b0;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Master exchange: send tx, bench returns rxp; exp_cyc 0 skips the timing check
  task automatic master_xfer(input logic [7:0] ctlv, input logic [7:0] tx,
                             input logic [7:0] rxp, input int exp_cyc, input string req);
    logic [7:0] d;
    int n;
    wr(2'd0, ctlv);
    cpol_b = ctlv[4];
    idle(2);
    chk("R5", "idle SCK level", sck_o, ctlv[4]);
    pat = rxp; bsdi = pat[7]; cap = 8'h00; lead_cnt = 0; prev_lvl = 1'b0;
    wr(2'd2, tx);
    n = 0;
    reg_addr = 2'd1;
    #1;
    while (!reg_rdata[0] && n < 5000) begin
      @(negedge clk);
      n++;
      #1;
    end
    if (exp_cyc != 0) chk(req, "cycles to buffer full", n, exp_cyc);
    chk("R4", "bits seen on SDO", cap, tx);
    chk("R4", "leading edges", lead_cnt, 8);
    rd(2'd2, d);
    chk("R4", "received byte", d, rxp);
    rd(2'd1, d);
    chk("R8", "full cleared by read", d, 8'h00);
  endtask

  // Bench acting as master toward the slave (SCK idle low)
  task automatic slave_send(input logic [7:0] tx, input int nbits, output logic [7:0] got);
    got = 8'h00;
    for (int i = 0; i < nbits; i++) begin
      bsdi = tx[7-i];
      idle(8);
      got = {got[6:0], sdo_o};
      bsck = 1'b1;
      idle(8);
      bsck = 1'b0;
    end
    idle(8);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(2'd0, d); chk("R1", "control after reset", d, 8'h00);
    rd(2'd1, d); chk("R1", "status after reset", d, 8'h00);
    chk("R1", "sck_oe after reset", sck_oe, 1'b0);
    chk("R1", "sdo_oe after reset", sdo_oe, 1'b0);
  endtask

  task automatic t_disabled;
    logic [7:0] d;
    wr(2'd0, 8'h00);
    wr(2'd2, 8'hAA);
    idle(50);
    chk("R2", "sck_oe disabled", sck_oe, 1'b0);
    chk("R2", "sdo_oe disabled", sdo_oe, 1'b0);
    rd(2'd1, d); chk("R2", "status disabled", d, 8'h00);
  endtask

  task automatic t_master_rates;
    master_xfer(8'h20, 8'hA5, 8'h3C, 32, "R3");
    master_xfer(8'h31, 8'h5A, 8'hC3, 128, "R3");
    master_xfer(8'h22, 8'h81, 8'h7E, 512, "R3");
    tmr_en = 1'b1;
    master_xfer(8'h33, 8'h96, 8'h69, 0, "R3");
    tmr_en = 1'b0;
  endtask

  task automatic t_collision;
    logic [7:0] d;
    wr(2'd0, 8'h20);
    cpol_b = 1'b0; pat = 8'h55; bsdi = pat[7]; cap = 8'h00; lead_cnt = 0; prev_lvl = 1'b0;
    wr(2'd2, 8'hF0);
    wr(2'd2, 8'h0F);
    idle(60);
    chk("R6", "byte in flight kept", cap, 8'hF0);
    rd(2'd0, d); chk("R6", "collision flag set", d, 8'hA0);
    wr(2'd0, 8'hA0);
    rd(2'd0, d); chk("R6", "flag kept on write 1", d, 8'hA0);
    wr(2'd0, 8'h20);
    rd(2'd0, d); chk("R6", "flag cleared on write 0", d, 8'h20);
    // Buffer still full: a second master byte must not raise overflow
    pat = 8'h33; bsdi = pat[7]; prev_lvl = 1'b0;
    wr(2'd2, 8'h11);
    idle(60);
    rd(2'd0, d); chk("R7", "no overflow in master", d, 8'h20);
    rd(2'd2, d); chk("R7", "master overwrites buffer", d, 8'h33);
  endtask

  task automatic t_overflow;
    logic [7:0] d, got;
    cpol_b = 1'b0; bsck = 1'b0; bss_n = 1'b1;
    wr(2'd0, 8'h25);
    idle(4);
    chk("R9", "SDO driven with select ignored", sdo_oe, 1'b1);
    wr(2'd2, 8'h6B);
    slave_send(8'h96, 8, got);
    chk("R4", "slave SDO bits", got, 8'h6B);
    rd(2'd1, d); chk("R11", "status full after slave byte", d, 8'h01);
    slave_send(8'h11, 8, got);
    rd(2'd0, d); chk("R7", "overflow flag", d, 8'h65);
    rd(2'd2, d); chk("R7", "older byte kept", d, 8'h96);
    wr(2'd0, 8'h25);
    rd(2'd0, d); chk("R7", "overflow cleared", d, 8'h25);
  endtask

  task automatic t_select;
    logic [7:0] d, got;
    bss_n = 1'b1;
    wr(2'd0, 8'h24);
    idle(4);
    chk("R9", "SDO released while deselected", sdo_oe, 1'b0);
    slave_send(8'hFF, 8, got);
    rd(2'd1, d); chk("R9", "no byte while deselected", d, 8'h00);
    bss_n = 1'b0;
    idle(4);
    chk("R9", "SDO driven when selected", sdo_oe, 1'b1);
    slave_send(8'hE0, 3, got);
    bss_n = 1'b1; idle(6);
    bss_n = 1'b0; idle(6);
    slave_send(8'h42, 8, got);
    rd(2'd2, d); chk("R9", "count restarted after select pulse", d, 8'h42);
    bss_n = 1'b1;
  endtask

  task automatic t_reserved;
    logic [7:0] d;
    wr(2'd0, 8'h27);
    wr(2'd2, 8'h55);
    idle(10);
    chk("R10", "sck_oe reserved", sck_oe, 1'b0);
    chk("R10", "sdo_oe reserved", sdo_oe, 1'b0);
    rd(2'd1, d); chk("R10", "status reserved", d, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_disabled();
    t_master_rates();
    t_collision();
    t_overflow();
    t_select();
    t_reserved();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule